// File: doc/BRIEF.md
# Parallel-Load Serial-Shift Register

This block is an eight-stage shift register with two ways to fill it. A byte can be written into every stage at once from a parallel input bus, or entered one bit at a time through a serial input. The parallel path is asynchronous and level-sensitive. While the load control is high, the stages follow the parallel bus with no clock edge needed, and the clock has no effect. While the load control is low, each rising clock edge moves the contents one stage toward the last stage.

Only the three last stages (stages 6, 7 and 8) drive outputs. A serial stream therefore reaches the outputs after a fixed latency. The last stage can be wired back to the serial input outside the block, which turns the register into a ring that rotates whatever was last loaded.

Top module: `pload_shreg`

## Requirements
- R1: Parallel bit `par_i[k]` belongs to stage k+1, and stage 1 is the entry stage. The outputs are `tap_o[0]` = stage 6, `tap_o[1]` = stage 7 and `tap_o[2]` = stage 8.
- R2: While `load_i` is 1, every stage equals its parallel bit. When `par_i` changes, the outputs follow without any clock edge.
- R3: While `load_i` is 0, each rising edge of `clk_i` moves stage 1 to take `ser_i` and stage n to take stage n-1.
- R4: A rising clock edge while `load_i` is 1 leaves the stages equal to the parallel bus.
- R5: After `load_i` falls, the stages keep the last loaded byte until the next rising clock edge. Changes on `par_i` in that interval do not reach the outputs.
- R6: Loading `par_i` = 8'b0011_0011 (stages 1..8 = 1,1,0,0,1,1,0,0) gives stage 6, 7, 8 = 1,0,0. The next three shifts give 1,1,0, then 0,1,1, then 0,0,1.
- R7: Eight serial shifts of 1,0,1,0,1,0,1,0, entering 1 first, give stage 6, 7, 8 = 1,0,1. Each further shift that continues the alternation inverts all three outputs.
- R8: Eight serial ones give all outputs 1, and eight serial zeros give all outputs 0.
- R9: With stage 8 fed back to `ser_i`, a loaded pattern of period 4 returns to its starting output state after every four shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock, rising edge active |
| load_i | input | 1 | High: asynchronous parallel load; low: shift on clock |
| ser_i | input | 1 | Serial data entering stage 1 |
| par_i | input | 8 | Parallel data; bit k goes to stage k+1 |
| tap_o | output | 3 | Stages 6, 7, 8 in bits 0, 1, 2 |

## Verification
A parallel load has no clock latency. The outputs are sampled a short settling delay after `load_i` or `par_i` changes, with the clock held low. A shift is due at the rising edge that causes it, so the outputs are sampled at the following falling edge. A serial bit reaches `tap_o[0]` on the sixth such edge after it is presented. A behavioural model of eight bits is advanced at each edge and compared after every edge and every load step, and the pattern checks add fixed expected values at the positions that R6 to R9 name.

// File: rtl/pload_shreg_pkg.sv
package pload_shreg_pkg;

    localparam int DEF_STAGES = 8;
    localparam int DEF_TAPS   = 3;

    // Move every stage one step toward the end and enter a new bit at stage 1.
    function automatic logic [DEF_STAGES-1:0] shift_in8(
        input logic [DEF_STAGES-1:0] cur,
        input logic                  bit_in
    );
        return {cur[DEF_STAGES-2:0], bit_in};
    endfunction

endpackage

// File: rtl/pload_shreg_next.sv
module pload_shreg_next #(
    parameter int STAGES = 8
) (
    input  logic [STAGES-1:0] cur_i,
    input  logic              ser_i,
    output logic [STAGES-1:0] nxt_o
);
    // Next-state for the shift path; the load path is handled per cell.
    generate
        if (STAGES == pload_shreg_pkg::DEF_STAGES) begin : g_pkg
            assign nxt_o = pload_shreg_pkg::shift_in8(cur_i, ser_i);
        end else begin : g_gen
            assign nxt_o = {cur_i[STAGES-2:0], ser_i};
        end
    endgenerate
endmodule

// File: rtl/pload_shreg_cell.sv
module pload_shreg_cell (
    input  logic clk_i,
    input  logic load_i,
    input  logic par_i,
    input  logic d_i,
    output logic q_o
);
    logic force_one;
    logic force_zero;
    logic q_q;

    // Level-sensitive load turned into an asynchronous preset or clear.
    assign force_one  = load_i &  par_i;
    assign force_zero = load_i & ~par_i;

    always_ff @(posedge clk_i or posedge force_zero or posedge force_one) begin
        if (force_zero) begin
            q_q <= 1'b0;
        end else if (force_one) begin
            q_q <= 1'b1;
        end else begin
            q_q <= d_i;
        end
    end

    assign q_o = q_q;
endmodule

// File: rtl/pload_shreg.sv
module pload_shreg #(
    parameter int STAGES = pload_shreg_pkg::DEF_STAGES,
    parameter int TAPS   = pload_shreg_pkg::DEF_TAPS
) (
    input  logic              clk_i,
    input  logic              load_i,
    input  logic              ser_i,
    input  logic [STAGES-1:0] par_i,
    output logic [TAPS-1:0]   tap_o
);
    localparam int TAP_LO = STAGES - TAPS;

    typedef struct packed {
        logic [STAGES-1:0] stage;
    } shreg_state_t;

    shreg_state_t      state_d;
    shreg_state_t      state_q;
    logic [STAGES-1:0] shifted;
    logic [STAGES-1:0] stage_q;

    pload_shreg_next #(.STAGES(STAGES)) next_i (
        .cur_i (state_q.stage),
        .ser_i (ser_i),
        .nxt_o (shifted)
    );

    always_comb begin
        state_d       = state_q;
        state_d.stage = shifted;
    end

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            pload_shreg_cell cell_i (
                .clk_i  (clk_i),
                .load_i (load_i),
                .par_i  (par_i[k]),
                .d_i    (state_d.stage[k]),
                .q_o    (state_q.stage[k])
            );
        end
    endgenerate

    assign stage_q = state_q.stage;
    assign tap_o   = stage_q[STAGES-1:TAP_LO];
endmodule

// File: rtl/pload_shreg_chk.sv
module pload_shreg_chk #(
    parameter int STAGES = 8,
    parameter int TAPS   = 3
) (
    input logic              clk_i,
    input logic              load_i,
    input logic              ser_i,
    input logic [STAGES-1:0] par_i,
    input logic [TAPS-1:0]   tap_o,
    input logic [STAGES-1:0] stage_q
);
    // High when the previous clock edge shifted and no load has occurred since.
    logic quiet_q;
    always_ff @(posedge clk_i or posedge load_i) begin
        if (load_i) quiet_q <= 1'b0;
        else        quiet_q <= 1'b1;
    end

    p_load_follow_r2: assert property (@(posedge clk_i)
        load_i |-> (tap_o == par_i[STAGES-1 -: TAPS]));

    p_clock_blocked_r4: assert property (@(posedge clk_i)
        (load_i && $past(load_i) && $stable(par_i)) |-> $stable(tap_o));

    p_tap_shift_r3: assert property (@(posedge clk_i) disable iff (load_i)
        quiet_q |-> (tap_o[TAPS-1:1] == $past(tap_o[TAPS-2:0])));

    p_entry_r3: assert property (@(posedge clk_i) disable iff (load_i)
        quiet_q |-> (stage_q[0] == $past(ser_i)));
endmodule

bind pload_shreg pload_shreg_chk #(.STAGES(STAGES), .TAPS(TAPS)) chk_i (
    .clk_i   (clk_i),
    .load_i  (load_i),
    .ser_i   (ser_i),
    .par_i   (par_i),
    .tap_o   (tap_o),
    .stage_q (stage_q)
);

// File: tb/pload_shreg_tb.sv
module pload_shreg_tb_top;
    localparam int PERIOD = 10;

    logic       clk_i  = 1'b0;
    logic       load_i = 1'b0;
    logic       ser_i  = 1'b0;
    logic [7:0] par_i  = 8'h00;
    logic [2:0] tap_o;

    int   n_chk  = 0;
    int   n_err  = 0;
    bit   done   = 1'b0;
    bit   ring   = 1'b0;
    bit   mdl [8];   // mdl[0] = stage 1

    pload_shreg dut_i (
        .clk_i  (clk_i),
        .load_i (load_i),
        .ser_i  (ser_i),
        .par_i  (par_i),
        .tap_o  (tap_o)
    );

    function automatic logic [2:0] mdl_taps();
        return {mdl[7], mdl[6], mdl[5]};
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: tap_o=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic mdl_load();
        for (int k = 0; k < 8; k++) mdl[k] = par_i[k];
    endtask

    // One clock period; model follows the edge, outputs sampled at the falling edge.
    task automatic tick(input logic s);
        if (ring) ser_i = tap_o[2];
        else      ser_i = s;
        #(PERIOD/2);
        clk_i = 1'b1;
        if (load_i) mdl_load();
        else begin
            for (int k = 7; k > 0; k--) mdl[k] = mdl[k-1];
            mdl[0] = ser_i;
        end
        #(PERIOD/2);
        clk_i = 1'b0;
        check("R3 model", tap_o, mdl_taps());
    endtask

    task automatic do_load(input logic [7:0] v);
        par_i  = v;
        load_i = 1'b1;
        #2;
        mdl_load();
        check("R2 load", tap_o, mdl_taps());
        load_i = 1'b0;
        #2;
    endtask

    initial begin
        #(PERIOD*200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: tap_o=%b expected=done", tap_o);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 / R6: stages 1..8 = 1,1,0,0,1,1,0,0
        do_load(8'b0011_0011);
        check("R1 tap mapping", tap_o, 3'b001);
        check("R6 after load", tap_o, 3'b001);
        tick(1'b0); check("R6 shift1", tap_o, 3'b011);
        tick(1'b0); check("R6 shift2", tap_o, 3'b110);
        tick(1'b0); check("R6 shift3", tap_o, 3'b100);

        // R7: alternating serial stream, 1 first
        for (int i = 0; i < 8; i++) tick((i % 2) == 0);
        check("R7 after eight", tap_o, 3'b101);
        tick(1'b1); check("R7 invert1", tap_o, 3'b010);
        tick(1'b0); check("R7 invert2", tap_o, 3'b101);

        // R8: fill with ones, then zeros
        for (int i = 0; i < 8; i++) tick(1'b1);
        check("R8 ones", tap_o, 3'b111);
        for (int i = 0; i < 8; i++) tick(1'b0);
        check("R8 zeros", tap_o, 3'b000);

        // R2: clock stopped, parallel bus changes during load
        load_i = 1'b1;
        par_i  = 8'b1010_0000; #2; mdl_load();
        check("R2 async a", tap_o, 3'b101);
        par_i  = 8'b0100_0000; #2; mdl_load();
        check("R2 async b", tap_o, 3'b010);
        par_i  = 8'b1110_0000; #2; mdl_load();
        check("R2 async c", tap_o, 3'b111);

        // R4: clock edges during load
        par_i = 8'b0110_0000; #2;
        tick(1'b1); check("R4 clock in load", tap_o, 3'b011);
        tick(1'b0); check("R4 clock in load 2", tap_o, 3'b011);
        mdl_load();

        // R5: release, then the bus changes without a clock
        load_i = 1'b0; #2;
        check("R5 hold", tap_o, 3'b011);
        par_i = 8'b1001_1111; #2;
        check("R5 bus ignored", tap_o, 3'b011);
        tick(1'b0); check("R5 first shift", tap_o, 3'b110);

        // R9: ring with stage 8 fed to the serial input
        do_load(8'b0011_0011);
        ring = 1'b1;
        for (int r = 0; r < 2; r++) begin
            tick(1'b0); check("R9 ring s1", tap_o, 3'b011);
            tick(1'b0); check("R9 ring s2", tap_o, 3'b110);
            tick(1'b0); check("R9 ring s3", tap_o, 3'b100);
            tick(1'b0); check("R9 ring back", tap_o, 3'b001);
        end
        do_load(8'b1100_1100);
        check("R9 second load", tap_o, 3'b110);
        for (int i = 0; i < 4; i++) tick(1'b0);
        check("R9 second back", tap_o, 3'b110);
        ring = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule